// File: doc/BRIEF.md
# Fractional-N Feedback Modulus Generator

This block sits in the digital part of a fractional-N PLL and, on every divider clock, hands the feedback divider the modulus to use for the next division. The modulus averages to an integer part plus a fine fraction. The fraction is formed by a third-order noise-shaping modulator. The modulator uses three cascaded first-order accumulators and a noise-cancelling combiner, so the quantization error is pushed towards high offset frequencies. The fraction always carries an extra half step. For a fraction code `F` of `FRAC_W` bits, the modulator is fed the odd value `2F+1` on `FRAC_W+1` bits. With `F = 0` the average is therefore still just above the integer part, and the sequence never settles to a fixed value.

The block holds two preset configuration words and picks one with a select line. Each word carries a pre-divider value, an integer part, a fraction code and a post-divider value. The select line crosses into the divider clock domain through a two-flop synchronizer. When the synchronized select changes, the new set's values take effect at once and the modulator state is cleared, so the next modulus comes only from the new set. The pre-divider and post-divider values of the active set are passed straight to the outputs.

Top module: `fracn_modgen`

## Requirements
- R1: While `rst_ni` is low and on release, `modulus_o` is 0, the synchronized select is 0, and `pre_div_o`/`post_div_o` show set 0.
- R2: Each config word is packed as {post, frac, int, pre} from MSB to LSB (widths POST_W, FRAC_W, INT_W, PRE_W). `pre_div_o` and `post_div_o` show the set chosen by `sel_i`, with 0 choosing `cfg0_i` and 1 choosing `cfg1_i`. A change on `sel_i` shows on these outputs after exactly two rising clock edges and not after one.
- R3: On the clock edge at which the new select first takes effect, the modulator state clears and `modulus_o` becomes exactly the new set's integer part.
- R4: With an integer part of 3 or more, every `modulus_o` after a normal (non-clearing) edge lies between the integer part minus 3 and the integer part plus 4.
- R5: For a fixed set, take the `2^(FRAC_W+1)` moduli that follow a clearing edge. Their sum equals INT·2^(FRAC_W+1) + 2·FRAC + 1, with at most −1/+2 of boundary residue left by the second and third modulator stages.
- R6: With a fraction code of 0, the modulus still dithers. At least one modulus in the window differs from the integer part, and the window sum stays within the R5 bounds around INT·2^(FRAC_W+1) + 1.
- R7: Near the limits of the integer range the modulus stays valid. With an integer part below 3, a negative result is clamped to 0 and never exceeds the integer part plus 4. With the largest integer part, the output (width INT_W+1) holds the top of the range without wrapping.
- R8: Writing the set that is not selected changes neither `pre_div_o`, `post_div_o` nor the modulus sequence of the active set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Configuration set select, asynchronous |
| cfg0_i | input | CFG_W | Configuration set 0 {post, frac, int, pre} |
| cfg1_i | input | CFG_W | Configuration set 1 {post, frac, int, pre} |
| modulus_o | output | INT_W+1 | Feedback division modulus for the current cycle |
| pre_div_o | output | PRE_W | Pre-divider value of the active set |
| post_div_o | output | POST_W | Post-divider value of the active set |

## Verification
The clear caused by a set switch and the normal modulator update compete for the same edge. The clear has to win outright, leaving no carry or delayed term from the old set. The bench forces this on every window by flipping `sel_i` while the modulator is running mid-sequence with nonzero delayed carries. It then checks that the first modulus after the switch is exactly the new integer part, and that the following full-period window sums to the new set's ideal value within the stated residue. Any leftover state from the old set would move that sum outside its narrow bounds. Writes to the unselected set are placed in the middle of windows and must leave both the outputs and the window sum unchanged.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int DEF_INT_W  = 7;
  localparam int DEF_FRAC_W = 18;
  localparam int DEF_PRE_W  = 2;
  localparam int DEF_POST_W = 7;
  // 1-1-1 cascade: correction spans -3..+4
  localparam int MASH_ORDER = 3;
  localparam int CORR_W     = 4;
  typedef logic signed [CORR_W-1:0] corr_t;
endpackage

// File: rtl/fracn_sel_sync.sv
module fracn_sel_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fracn_acc_stage.sv
module fracn_acc_stage #(
  parameter int W = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   wide;

  assign wide    = {1'b0, acc_q} + {1'b0, add_i};
  assign sum_o   = wide[W-1:0];
  assign carry_o = wide[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= wide[W-1:0];
  end
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
  import fracn_pkg::*;
#(
  parameter int ACC_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] frac_i,
  output corr_t            corr_o
);
  logic [ACC_W-1:0]      sum   [MASH_ORDER];
  logic [MASH_ORDER-1:0] carry;

  for (genvar k = 0; k < MASH_ORDER; k++) begin : g_stage
    logic [ACC_W-1:0] add;
    if (k == 0) begin : g_first
      assign add = frac_i;
    end else begin : g_chain
      assign add = sum[k-1];
    end
    fracn_acc_stage #(.W(ACC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .add_i   (add),
      .sum_o   (sum[k]),
      .carry_o (carry[k])
    );
  end

  // delayed carries for the differentiators of stages 2 and 3
  logic c2_d, c3_d, c3_dd;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_d <= 1'b0; c3_d <= 1'b0; c3_dd <= 1'b0;
    end else if (clr_i) begin
      c2_d <= 1'b0; c3_d <= 1'b0; c3_dd <= 1'b0;
    end else begin
      c2_d  <= carry[1];
      c3_d  <= carry[2];
      c3_dd <= c3_d;
    end
  end

  // y = c1 + (1-z^-1)c2 + (1-z^-1)^2 c3
  assign corr_o = $signed({3'b000, carry[0]})
                + $signed({3'b000, carry[1]}) - $signed({3'b000, c2_d})
                + $signed({3'b000, carry[2]}) - $signed({2'b00, c3_d, 1'b0})
                + $signed({3'b000, c3_dd});

  assert_corr_span_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o >= -4'sd3) && (corr_o <= 4'sd4));
endmodule

// File: rtl/fracn_modgen.sv
module fracn_modgen
  import fracn_pkg::*;
#(
  parameter int INT_W  = DEF_INT_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int PRE_W  = DEF_PRE_W,
  parameter int POST_W = DEF_POST_W,
  localparam int CFG_W = POST_W + FRAC_W + INT_W + PRE_W,
  localparam int MOD_W = INT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [CFG_W-1:0]  cfg0_i,
  input  logic [CFG_W-1:0]  cfg1_i,
  output logic [MOD_W-1:0]  modulus_o,
  output logic [PRE_W-1:0]  pre_div_o,
  output logic [POST_W-1:0] post_div_o
);
  localparam int ACC_W  = FRAC_W + 1;
  localparam int SUM_W  = MOD_W + 1;
  localparam int INT_LO = PRE_W;
  localparam int FRC_LO = PRE_W + INT_W;
  localparam int PST_LO = PRE_W + INT_W + FRAC_W;
  localparam logic [INT_W-1:0] SAFE_INT = INT_W'(3);

  logic sel_s, sel_d, switch_s;

  fracn_sel_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sel_i),
    .q_o    (sel_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_d <= 1'b0;
    else         sel_d <= sel_s;
  end
  assign switch_s = sel_s ^ sel_d;

  logic [CFG_W-1:0]  act_cfg;
  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;

  assign act_cfg    = sel_s ? cfg1_i : cfg0_i;
  assign pre_div_o  = act_cfg[PRE_W-1:0];
  assign act_int    = act_cfg[FRC_LO-1:INT_LO];
  assign act_frac   = act_cfg[PST_LO-1:FRC_LO];
  assign post_div_o = act_cfg[CFG_W-1:PST_LO];

  corr_t corr;

  fracn_mash #(.ACC_W(ACC_W)) u_mash (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (switch_s),
    .frac_i ({act_frac, 1'b1}),   // half-LSB offset
    .corr_o (corr)
  );

  logic signed [SUM_W-1:0] raw;
  logic [MOD_W-1:0]        mod_next;
  logic [MOD_W-1:0]        mod_q;

  assign raw = $signed({2'b00, act_int})
             + $signed({{(SUM_W-CORR_W){corr[CORR_W-1]}}, corr});
  assign mod_next = raw[SUM_W-1] ? '0 : raw[MOD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mod_q <= '0;
    else if (switch_s) mod_q <= {1'b0, act_int};
    else               mod_q <= mod_next;
  end
  assign modulus_o = mod_q;

  // cycles since reset, for the synchronizer latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_sync_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2) |-> (sel_s == $past(sel_i, 2)));

  assert_switch_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_s |=> (modulus_o == {1'b0, $past(act_int)}));

  assert_mod_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!switch_s && act_int >= SAFE_INT) |=>
      ((int'(modulus_o) >= int'($past(act_int)) - 3) &&
       (int'(modulus_o) <= int'($past(act_int)) + 4)));

  assert_low_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!switch_s && act_int < SAFE_INT) |=>
      (int'(modulus_o) <= int'($past(act_int)) + 4));
endmodule

// File: tb/fracn_modgen_bench.sv
`timescale 1ns/1ps
module fracn_modgen_bench;
  localparam int IW = 7;
  localparam int FW = 10;
  localparam int PW = 2;
  localparam int QW = 7;
  localparam int CW = QW + FW + IW + PW;
  localparam int MW = IW + 1;
  localparam int WIN = 1 << (FW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic [CW-1:0] cfg [2];
  logic [MW-1:0] mod_o;
  logic [PW-1:0] pre_o;
  logic [QW-1:0] post_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fracn_modgen #(.INT_W(IW), .FRAC_W(FW), .PRE_W(PW), .POST_W(QW)) u_fracn_modgen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sel_i      (sel),
    .cfg0_i     (cfg[0]),
    .cfg1_i     (cfg[1]),
    .modulus_o  (mod_o),
    .pre_div_o  (pre_o),
    .post_div_o (post_o)
  );

  function automatic logic [CW-1:0] pack(int pre, int mint, int frac, int post);
    return {QW'(post), FW'(frac), IW'(mint), PW'(pre)};
  endfunction
  function automatic int f_pre(logic [CW-1:0] w);  return int'(w[PW-1:0]); endfunction
  function automatic int f_int(logic [CW-1:0] w);  return int'(w[PW+IW-1:PW]); endfunction
  function automatic int f_frac(logic [CW-1:0] w); return int'(w[PW+IW+FW-1:PW+IW]); endfunction
  function automatic int f_post(logic [CW-1:0] w); return int'(w[CW-1:PW+IW+FW]); endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // load the idle set, flip select, check switch timing and one full window
  task automatic run_window(int mint, int frac);
    int     old_s, new_s, below, above, lo_lim, hi_lim;
    longint sum, ideal;
    bit     dith;
    old_s = int'(sel);
    new_s = 1 - old_s;
    cfg[new_s] = pack($urandom_range(3), mint, frac, $urandom_range(127));
    sel = new_s[0];
    tick();
    chk(pre_o == PW'(f_pre(cfg[old_s])) && post_o == QW'(f_post(cfg[old_s])),
        "R2 one edge", longint'(post_o), f_post(cfg[old_s]));
    tick();
    chk(pre_o == PW'(f_pre(cfg[new_s])) && post_o == QW'(f_post(cfg[new_s])),
        "R2 two edges", longint'(post_o), f_post(cfg[new_s]));
    tick();
    chk(int'(mod_o) == mint, "R3 clear", longint'(mod_o), mint);
    sum = 0; below = 0; above = 0; dith = 1'b0;
    lo_lim = (mint >= 3) ? mint - 3 : 0;
    hi_lim = mint + 4;
    for (int i = 0; i < WIN; i++) begin
      tick();
      sum += longint'(mod_o);
      if (int'(mod_o) != mint) dith = 1'b1;
      if (int'(mod_o) < lo_lim) below++;
      if (int'(mod_o) > hi_lim) above++;
      if (i == WIN / 2) begin
        cfg[old_s] = pack($urandom_range(3), $urandom_range(127),
                          $urandom_range((1 << FW) - 1), $urandom_range(127));
        #1;
        chk(pre_o == PW'(f_pre(cfg[new_s])) && post_o == QW'(f_post(cfg[new_s])),
            "R8 idle write", longint'(post_o), f_post(cfg[new_s]));
      end
    end
    chk(below == 0 && above == 0, (mint < 3) ? "R7 range" : "R4 range",
        longint'(below + above), 0);
    ideal = longint'(mint) * WIN + 2 * frac + 1;
    if (mint >= 3)
      chk(sum >= ideal - 1 && sum <= ideal + 2, "R5 window sum", sum, ideal);
    else
      chk(sum >= ideal - 1, "R7 clamped sum", sum, ideal);
    if (frac == 0)
      chk(dith, "R6 dither", longint'(dith), 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    cfg[0] = pack(2, 40, 300, 9);
    cfg[1] = pack(1, 90, 7, 33);
    #1;
    chk(mod_o == '0 && pre_o == 2'd2 && post_o == 7'd9, "R1 in reset", longint'(mod_o), 0);
    #20 rst_n = 1'b1;
    #1;
    chk(mod_o == '0 && pre_o == 2'd2 && post_o == 7'd9, "R1 release", longint'(post_o), 9);
    repeat (5) tick();
    run_window(50, 0);                     // R6 zero fraction
    run_window(127, (1 << FW) - 1);        // R7 top of range, largest fraction
    run_window(0, 5);                      // R7 clamp at zero
    run_window(1, 0);                      // R7 clamp with zero fraction
    run_window(3, (1 << FW) / 2);          // R4 lowest unclamped integer
    for (int r = 0; r < 5; r++)
      run_window(3 + $urandom_range(124), $urandom_range((1 << FW) - 1));  // R5 random
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule